// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a true dual-port memory with two fully independent ports, called left and right. Each port has an active-low chip enable, an address, an active-low write strobe, a write data bus and a registered read data bus. With the default parameters the array holds 1024 words of 16 bits. Setting `ADDR_W` to 14 gives the full 16384-word organisation with address bits 0 to 13 on each port. Both ports may read or write in the same cycle. Neither port ever waits for the other.

A collision arbiter watches the two ports. When both are enabled on the same address, the port that was already there proceeds, and the late port sees an active-low busy flag. The late port's write is gated off internally, so a blocked write leaves the array untouched. The arbiter looks only at enables and addresses, never at the write strobes. The `master_mode` input selects who decides busy:
- In master mode, the arbiter decides and drives both busy pins.
- In slave mode, the busy pins are held high. A separate busy input per port becomes a plain write inhibit. This lets several devices laid side by side for a wider word follow one master's decision.

The arbiter is a three-state machine whose decision for the current cycle (the next state) is used at once.
- States:
  - `ARB_IDLE`: no collision.
  - `ARB_LEFT_WINS`: the right port is busy.
  - `ARB_RIGHT_WINS`: the left port is busy.
- Transitions:
  - Any state with no collision goes to `ARB_IDLE`.
  - On a new collision where only the right port was held at that address in the previous cycle, the machine goes to `ARB_RIGHT_WINS`. Otherwise, including a tie and the case where only the left port was held, it goes to `ARB_LEFT_WINS`.
  - A winning state with both ports held stays put.
  - A winning state where both ports moved together to a new common address is decided afresh, as a new collision.

Top module: `dpram_collision`

## Requirements
- R1: The array stores 2^ADDR_W words of DATA_W bits. A write (chip enable low, write strobe low) at a clock edge is stored. A read (chip enable low, write strobe high) presents the stored word on that port's read data one clock edge later. Read data is zero after reset.
- R2: In master mode, when either chip enable is high or the addresses differ, both busy outputs are high (1 = not busy).
- R3: In master mode, when the addresses match with both enables low, busy goes low only on the port that arrived later. The earlier port is the one whose enable was low at the same address in the previous cycle while the other port's was not.
- R4: When both ports begin a matching access in the same cycle, the left port wins and the right busy goes low. The two busy outputs are never low together.
- R5: A write from a port whose busy is low is suppressed, and the stored word keeps its old value.
- R6: Arbitration ignores the write strobes. A read that gets busy still returns the stored word.
- R7: Busy stays low on the losing port for as long as the winner keeps its enable low at the same address. It clears in the cycle the winner raises its enable or changes address.
- R8: In slave mode (`master_mode` = 0), both busy outputs stay high even on a collision. A low on a port's busy input blocks writes on that port only.
- R9: In slave mode, with both busy inputs high, both ports write normally.
- R10: Accesses on the two ports at different addresses in the same cycle complete independently, with no added delay on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbiter drives busy, 0 = busy inputs inhibit writes |
| ce_l_n | input | 1 | Left chip enable, active low |
| we_l_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| addr_l | input | ADDR_W | Left address |
| wdata_l | input | DATA_W | Left write data |
| rdata_l | output | DATA_W | Left read data, registered |
| busy_l_n_o | output | 1 | Left busy flag, active low |
| busy_l_n_i | input | 1 | Left write inhibit in slave mode, active low |
| ce_r_n | input | 1 | Right chip enable, active low |
| we_r_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| addr_r | input | ADDR_W | Right address |
| wdata_r | input | DATA_W | Right write data |
| rdata_r | output | DATA_W | Right read data, registered |
| busy_r_n_o | output | 1 | Right busy flag, active low |
| busy_r_n_i | input | 1 | Right write inhibit in slave mode, active low |

## Verification
The busy outputs are combinational from the current enables and addresses plus one cycle of arrival history. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and samples busy one time unit later, before the rising edge. A write or a blocked write takes effect at the next rising edge. Read data appears after that same edge. The bench therefore reads back one falling edge after issuing the read, which means a blocked write is confirmed two edges after it was attempted. The "earlier" rule in R3 and the hold in R7 depend on the previous cycle. Each collision scenario therefore opens with an idle cycle, so the history is known.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_WINS  = 2'd1,
        ARB_RIGHT_WINS = 2'd2
    } arb_state_e;

    localparam int SIDE_L    = 0;
    localparam int SIDE_R    = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SIDES-1:0]                ce_n,
    input  logic [NUM_SIDES-1:0][ADDR_W-1:0]    addr,
    output logic [NUM_SIDES-1:0]                arb_busy_n
);

    arb_state_e                             state_q, state_d, fresh;
    logic [NUM_SIDES-1:0]                   act, prev_act_q, held;
    logic [NUM_SIDES-1:0][ADDR_W-1:0]       prev_addr_q;
    logic                                   match;

    assign act   = ~ce_n;
    assign match = act[SIDE_L] & act[SIDE_R] & (addr[SIDE_L] == addr[SIDE_R]);

    // a side is "held" when it sat at the same address, enabled, last cycle
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_held
        assign held[s] = act[s] & prev_act_q[s] & (prev_addr_q[s] == addr[s]);
    end

    // next-state decision, used in the same cycle to gate writes
    always_comb begin
        fresh   = (held[SIDE_R] && !held[SIDE_L]) ? ARB_RIGHT_WINS : ARB_LEFT_WINS;
        state_d = ARB_IDLE;
        if (match) begin
            unique case (state_q)
                ARB_LEFT_WINS,
                ARB_RIGHT_WINS: state_d = (&held) ? state_q : fresh;
                ARB_IDLE:       state_d = fresh;
                default:        state_d = fresh;
            endcase
        end
    end

    // state register and arrival history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ARB_IDLE;
            prev_act_q  <= '0;
            prev_addr_q <= '0;
        end else begin
            state_q     <= state_d;
            prev_act_q  <= act;
            prev_addr_q <= addr;
        end
    end

    // outputs from the current decision
    always_comb begin
        arb_busy_n = '1;
        unique case (state_d)
            ARB_LEFT_WINS:  arb_busy_n[SIDE_R] = 1'b0;
            ARB_RIGHT_WINS: arb_busy_n[SIDE_L] = 1'b0;
            ARB_IDLE:       arb_busy_n = '1;
            default:        arb_busy_n = '1;
        endcase
    end

endmodule

// File: rtl/dpram_wgate.sv
module dpram_wgate (
    input  logic master_mode,
    input  logic ce_n,
    input  logic we_n,
    input  logic arb_busy_n,
    input  logic ext_busy_n,
    output logic wr_en,
    output logic rd_en,
    output logic busy_pin_n
);

    logic inhibit_n;

    // the internal decision gates writes in master mode, the pin in slave mode
    assign inhibit_n  = master_mode ? arb_busy_n : ext_busy_n;
    assign wr_en      = !ce_n && !we_n && inhibit_n;
    assign rd_en      = !ce_n && we_n;
    assign busy_pin_n = master_mode ? arb_busy_n : 1'b1;

endmodule

// File: rtl/dpram_storage.sv
module dpram_storage
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SIDES-1:0]                wr_en,
    input  logic [NUM_SIDES-1:0]                rd_en,
    input  logic [NUM_SIDES-1:0][ADDR_W-1:0]    addr,
    input  logic [NUM_SIDES-1:0][DATA_W-1:0]    wdata,
    output logic [NUM_SIDES-1:0][DATA_W-1:0]    rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q [NUM_SIDES];

    // both write ports in one process; arbitration keeps same-address writes apart
    always_ff @(posedge clk) begin
        if (wr_en[SIDE_L]) mem[addr[SIDE_L]] <= wdata[SIDE_L];
        if (wr_en[SIDE_R]) mem[addr[SIDE_R]] <= wdata[SIDE_R];
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)        rd_q[g] <= '0;
            else if (rd_en[g]) rd_q[g] <= mem[addr[g]];
        end
        assign rdata[g] = rd_q[g];
    end

endmodule

// File: rtl/dpram_collision.sv
module dpram_collision
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              ce_l_n,
    input  logic              we_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    output logic              busy_l_n_o,
    input  logic              busy_l_n_i,
    input  logic              ce_r_n,
    input  logic              we_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r,
    output logic              busy_r_n_o,
    input  logic              busy_r_n_i
);

    logic [NUM_SIDES-1:0]               ce_n, we_n, ext_busy_n, arb_busy_n;
    logic [NUM_SIDES-1:0]               wr_en, rd_en, pin_busy_n;
    logic [NUM_SIDES-1:0][ADDR_W-1:0]   addr;
    logic [NUM_SIDES-1:0][DATA_W-1:0]   wdata, rdata;

    assign ce_n       = {ce_r_n, ce_l_n};
    assign we_n       = {we_r_n, we_l_n};
    assign ext_busy_n = {busy_r_n_i, busy_l_n_i};
    assign addr       = {addr_r, addr_l};
    assign wdata      = {wdata_r, wdata_l};

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .addr       (addr),
        .arb_busy_n (arb_busy_n)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        dpram_wgate u_gate (
            .master_mode (master_mode),
            .ce_n        (ce_n[g]),
            .we_n        (we_n[g]),
            .arb_busy_n  (arb_busy_n[g]),
            .ext_busy_n  (ext_busy_n[g]),
            .wr_en       (wr_en[g]),
            .rd_en       (rd_en[g]),
            .busy_pin_n  (pin_busy_n[g])
        );
    end

    dpram_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign rdata_l    = rdata[SIDE_L];
    assign rdata_r    = rdata[SIDE_R];
    assign busy_l_n_o = pin_busy_n[SIDE_L];
    assign busy_r_n_o = pin_busy_n[SIDE_R];

endmodule

// File: rtl/dpram_collision_chk.sv
module dpram_collision_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              ce_l_n,
    input logic              ce_r_n,
    input logic [ADDR_W-1:0] addr_l,
    input logic [ADDR_W-1:0] addr_r,
    input logic              busy_l_n_o,
    input logic              busy_r_n_o,
    input logic              busy_l_n_i,
    input logic              busy_r_n_i,
    input logic [1:0]        wr_en
);

    logic coll;
    assign coll = !ce_l_n && !ce_r_n && (addr_l == addr_r);

    p_never_both_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_l_n_o && !busy_r_n_o));

    p_no_match_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !coll) |-> (busy_l_n_o && busy_r_n_o));

    p_one_side_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && coll) |-> (busy_l_n_o != busy_r_n_o));

    p_left_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && coll && $past(rst_n) && $past(!ce_l_n) && $stable(addr_l)
         && !($past(!ce_r_n) && $stable(addr_r))) |-> !busy_r_n_o);

    p_right_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && coll && $past(rst_n) && $past(!ce_r_n) && $stable(addr_r)
         && !($past(!ce_l_n) && $stable(addr_l))) |-> !busy_l_n_o);

    p_tie_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && coll && $past(rst_n)
         && !($past(!ce_l_n) && $stable(addr_l))
         && !($past(!ce_r_n) && $stable(addr_r))) |-> !busy_r_n_o);

    p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !busy_r_n_o) |=>
        (!(master_mode && coll && $stable(addr_l) && $stable(addr_r)) || !busy_r_n_o));

    p_hold_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !busy_l_n_o) |=>
        (!(master_mode && coll && $stable(addr_l) && $stable(addr_r)) || !busy_l_n_o));

    p_block_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !busy_l_n_o) |-> !wr_en[0]);

    p_block_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !busy_r_n_o) |-> !wr_en[1]);

    p_slave_pins_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (busy_l_n_o && busy_r_n_o));

    p_slave_inhibit_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !busy_l_n_i) |-> !wr_en[0]);

    p_slave_inhibit_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !busy_r_n_i) |-> !wr_en[1]);

endmodule

bind dpram_collision dpram_collision_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .ce_l_n      (ce_l_n),
    .ce_r_n      (ce_r_n),
    .addr_l      (addr_l),
    .addr_r      (addr_r),
    .busy_l_n_o  (busy_l_n_o),
    .busy_r_n_o  (busy_r_n_o),
    .busy_l_n_i  (busy_l_n_i),
    .busy_r_n_i  (busy_r_n_i),
    .wr_en       (wr_en)
);

// File: tb/test_dpram_collision.sv
module test_dpram_collision;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n, master_mode;
    logic              ce_l_n, we_l_n, busy_l_n_i, ce_r_n, we_r_n, busy_r_n_i;
    logic [ADDR_W-1:0] addr_l, addr_r;
    logic [DATA_W-1:0] wdata_l, wdata_r, rdata_l, rdata_r;
    logic              busy_l_n_o, busy_r_n_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_collision #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpram_collision (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .ce_l_n(ce_l_n), .we_l_n(we_l_n), .addr_l(addr_l), .wdata_l(wdata_l),
        .rdata_l(rdata_l), .busy_l_n_o(busy_l_n_o), .busy_l_n_i(busy_l_n_i),
        .ce_r_n(ce_r_n), .we_r_n(we_r_n), .addr_r(addr_r), .wdata_r(wdata_r),
        .rdata_r(rdata_r), .busy_r_n_o(busy_r_n_o), .busy_r_n_i(busy_r_n_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic l_wr(input int a, input logic [DATA_W-1:0] d);
        ce_l_n = 0; we_l_n = 0; addr_l = a[ADDR_W-1:0]; wdata_l = d;
    endtask
    task automatic l_rd(input int a);
        ce_l_n = 0; we_l_n = 1; addr_l = a[ADDR_W-1:0];
    endtask
    task automatic l_off();
        ce_l_n = 1; we_l_n = 1;
    endtask
    task automatic r_wr(input int a, input logic [DATA_W-1:0] d);
        ce_r_n = 0; we_r_n = 0; addr_r = a[ADDR_W-1:0]; wdata_r = d;
    endtask
    task automatic r_rd(input int a);
        ce_r_n = 0; we_r_n = 1; addr_r = a[ADDR_W-1:0];
    endtask
    task automatic r_off();
        ce_r_n = 1; we_r_n = 1;
    endtask
    task automatic both_off();
        l_off(); r_off(); tick();
    endtask

    // busy-low on both sides is never allowed
    always @(negedge clk) begin
        #3;
        if (rst_n === 1'b1 && busy_l_n_o === 1'b0 && busy_r_n_o === 1'b0) begin
            n_bad++;
            $display("FAIL R4 both busy low: actual 00 expected not 00");
        end
    end

    task automatic t_reset();
        #1;
        chk("R2", "reset busy_l", busy_l_n_o, 1);
        chk("R2", "reset busy_r", busy_r_n_o, 1);
        chk("R1", "reset rdata_l", rdata_l, 0);
        chk("R1", "reset rdata_r", rdata_r, 0);
    endtask

    task automatic t_independent();
        l_wr(5, 16'h1111); r_wr(9, 16'h2222); #1;
        chk("R2", "diff addr busy_l", busy_l_n_o, 1);
        chk("R2", "diff addr busy_r", busy_r_n_o, 1);
        tick();
        l_rd(9); r_rd(5); tick();
        chk("R10", "left reads right's word", rdata_l, 16'h2222);
        chk("R1", "right reads left's word", rdata_r, 16'h1111);
        both_off();
    endtask

    task automatic t_left_first();
        l_wr(20, 16'hAAAA); tick(); both_off();
        l_rd(20); tick();
        r_wr(20, 16'h5555); #1;
        chk("R3", "left first busy_r", busy_r_n_o, 0);
        chk("R3", "left first busy_l", busy_l_n_o, 1);
        tick(); both_off();
        l_rd(20); tick();
        chk("R5", "blocked right write", rdata_l, 16'hAAAA);
        both_off();
    endtask

    task automatic t_right_first();
        r_wr(30, 16'h1234); tick(); both_off();
        r_rd(30); tick();
        l_wr(30, 16'hDEAD); #1;
        chk("R3", "right first busy_l", busy_l_n_o, 0);
        chk("R3", "right first busy_r", busy_r_n_o, 1);
        tick(); both_off();
        r_rd(30); tick();
        chk("R5", "blocked left write", rdata_r, 16'h1234);
        both_off();
    endtask

    task automatic t_tie();
        l_wr(40, 16'h4040); tick(); both_off();
        l_wr(40, 16'h1111); r_wr(40, 16'h2222); #1;
        chk("R4", "tie busy_r", busy_r_n_o, 0);
        chk("R4", "tie busy_l", busy_l_n_o, 1);
        tick(); both_off();
        r_rd(40); tick();
        chk("R4", "tie left write kept", rdata_r, 16'h1111);
        both_off();
    endtask

    task automatic t_read_collision();
        r_wr(50, 16'h5050); tick(); both_off();
        l_rd(50); tick();
        r_rd(50); #1;
        chk("R6", "read-only collision busy_r", busy_r_n_o, 0);
        chk("R6", "read-only collision busy_l", busy_l_n_o, 1);
        tick();
        chk("R6", "busy read data", rdata_r, 16'h5050);
        chk("R6", "winner read data", rdata_l, 16'h5050);
        both_off();
    endtask

    task automatic t_hold();
        l_wr(60, 16'h6060); tick(); both_off();
        l_rd(60); tick();
        r_rd(60); #1;
        chk("R3", "hold start busy_r", busy_r_n_o, 0);
        tick();
        r_wr(60, 16'hBEEF); #1;
        chk("R7", "held busy_r while strobe changes", busy_r_n_o, 0);
        tick();
        r_rd(60); l_rd(61); #1;
        chk("R7", "winner moved busy_r", busy_r_n_o, 1);
        chk("R2", "winner moved busy_l", busy_l_n_o, 1);
        tick();
        l_rd(60); #1;
        chk("R3", "right now earlier busy_l", busy_l_n_o, 0);
        tick();
        r_off(); #1;
        chk("R7", "winner dropped enable busy_l", busy_l_n_o, 1);
        tick();
        chk("R5", "held write blocked", rdata_l, 16'h6060);
        both_off();
    endtask

    task automatic t_slave();
        l_wr(70, 16'h7070); tick(); both_off();
        master_mode = 0; busy_l_n_i = 0; busy_r_n_i = 1;
        l_wr(70, 16'hBAD1); r_wr(71, 16'h7171); #1;
        chk("R8", "slave busy_l pin", busy_l_n_o, 1);
        tick();
        l_rd(70); r_rd(71); tick();
        chk("R8", "slave left inhibited", rdata_l, 16'h7070);
        chk("R8", "slave right unaffected", rdata_r, 16'h7171);
        both_off();
        busy_l_n_i = 1; busy_r_n_i = 0;
        l_wr(72, 16'h7272); r_wr(72, 16'hBAD2); #1;
        chk("R8", "slave collision busy_r pin", busy_r_n_o, 1);
        chk("R8", "slave collision busy_l pin", busy_l_n_o, 1);
        tick();
        r_rd(72); tick();
        chk("R8", "slave right inhibited", rdata_r, 16'h7272);
        both_off();
        busy_l_n_i = 1; busy_r_n_i = 1;
        l_wr(73, 16'hA1A1); r_wr(74, 16'hB2B2); tick();
        l_rd(74); r_rd(73); tick();
        chk("R9", "slave normal left", rdata_l, 16'hB2B2);
        chk("R9", "slave normal right", rdata_r, 16'hA1A1);
        both_off();
        master_mode = 1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        rst_n = 0; master_mode = 1; busy_l_n_i = 1; busy_r_n_i = 1;
        ce_l_n = 1; we_l_n = 1; addr_l = '0; wdata_l = '0;
        ce_r_n = 1; we_r_n = 1; addr_r = '0; wdata_r = '0;
        repeat (3) tick();
        t_reset();
        rst_n = 1;
        tick();
        t_independent();
        t_left_first();
        t_right_first();
        t_tie();
        t_read_collision();
        t_hold();
        t_slave();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule